// File: doc/BRIEF.md
# Two-Pixel Triangle Rasterizer

This block fills one flat-colored triangle into a 32-bit-per-pixel framebuffer, two pixels per memory word. A triangle arrives as three integer vertex positions and a color through a valid/ready command port. The block walks the triangle's bounding box row by row, one horizontally aligned pixel pair per clock. For each pair it emits a 64-bit write whose byte enables select, independently, the even pixel, the odd pixel, or both.

Coverage comes from three edge functions that are stepped by additions only. The even pixel and the odd pixel each get their own inside test in the same cycle. The winding is normalised once per triangle, so a single sign test decides coverage. A fill rule on each edge makes sure that a pixel lying exactly on an edge shared by two triangles is drawn by only one of them.

Top module: `tri_pair_raster`

## Requirements
- R1: `cmd_ready` is high exactly when the block is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `busy` is high from the next cycle until the edge on which the last write is accepted, and `cmd_ready` is low during that time.
- R2: The set of pixels written does not depend on the order or the winding in which the three vertices are given.
- R3: Put the vertices in order so that D = (x1-x0)(y2-y0) - (x2-x0)(y1-y0) is positive. For the edges (v0,v1), (v1,v2) and (v2,v0), define E_ab(p) = (bx-ax)(py-ay) - (by-ay)(px-ax). An edge is owning when ay > by, or when ay == by and bx < ax. Pixel (px,py) is drawn exactly when every edge has E > 0, or has E == 0 and is owning.
- R4: When two triangles share an edge, no pixel is written by both of them.
- R5: The word address is y * 2^(CW-1) + x/2 for the pair whose even pixel is at x. The data is the color repeated in both 32-bit halves. `wr_be[3:0]` is all ones exactly when the even pixel is drawn. `wr_be[7:4]` is all ones exactly when the odd pixel (x+1) is drawn. Each half is decided on its own, so an odd pixel never copies the even pixel's result.
- R6: No write has an all-zero byte enable. Writes are issued in ascending row order, and left to right within a row.
- R7: Only pairs inside the box are visited. That box runs in x from the minimum vertex x rounded down to even up to the maximum vertex x, and in y from the minimum to the maximum vertex y. No write is presented while `busy` is low.
- R8: With `wr_ready` held high, `busy` stays high for exactly 2 + rows × pairs-per-row cycles. That is one write slot per clock.
- R9: A triangle with D = 0 produces no writes. `busy` stays high for exactly one cycle, and then the next command is accepted.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_be` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Triangle command valid |
| cmd_ready | output | 1 | Block idle, command can be taken |
| v0_x | input | CW | Vertex 0 x |
| v0_y | input | CW | Vertex 0 y |
| v1_x | input | CW | Vertex 1 x |
| v1_y | input | CW | Vertex 1 y |
| v2_x | input | CW | Vertex 2 x |
| v2_y | input | CW | Vertex 2 y |
| color | input | PW | Flat pixel color |
| busy | output | 1 | Triangle in progress |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts write |
| wr_addr | output | 2*CW-1 | Word address of the pixel pair |
| wr_data | output | 2*PW | Color duplicated into both halves |
| wr_be | output | PW/4 | Byte enables, low half for even pixel |

## Verification
Several internal faults show up at the write port on the first affected triangle. A wrong incremental step or row reload shows up as the wrong byte enables on the second pair or second row. A swapped orientation or a missing fill-rule bias shows up as extra or missing pixels along a triangle edge. The bench compares every accepted write, in order, against a direct per-pixel evaluation of the edge equations. Because of that, a single wrong mask bit, address or extra write is reported at the point it occurs. The busy-cycle counts with the write port always ready expose any lost or added scan cycle within the same triangle.

// File: rtl/tri_pair_raster.sv
module tri_pair_raster #(
  parameter int CW = 8,
  parameter int PW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [CW-1:0]       v0_x,
  input  logic [CW-1:0]       v0_y,
  input  logic [CW-1:0]       v1_x,
  input  logic [CW-1:0]       v1_y,
  input  logic [CW-1:0]       v2_x,
  input  logic [CW-1:0]       v2_y,
  input  logic [PW-1:0]       color,
  output logic                busy,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [2*CW-2:0]     wr_addr,
  output logic [2*PW-1:0]     wr_data,
  output logic [PW/4-1:0]     wr_be
);
  localparam int EW = 2*CW + 4;
  localparam int HB = PW/8;

  typedef enum logic [1:0] {S_IDLE, S_ORIENT, S_PREP, S_SCAN} state_t;
  state_t state;

  logic [CW-1:0] vx [3];
  logic [CW-1:0] vy [3];
  logic [PW-1:0] color_q;

  logic signed [EW-1:0] a_q [3];
  logic signed [EW-1:0] b_q [3];
  logic signed [EW-1:0] e_row [3];
  logic signed [EW-1:0] e_cur [3];
  logic [2:0] own_q;
  logic [CW-1:0] x_q, y_q, xs_q, xl_q, ymax_q;

  function automatic logic signed [EW-1:0] ext(input logic [CW-1:0] v);
    ext = $signed({{(EW-CW){1'b0}}, v});
  endfunction

  function automatic logic [CW-1:0] min3(input logic [CW-1:0] a, b, c);
    logic [CW-1:0] m;
    m = (a < b) ? a : b;
    min3 = (c < m) ? c : m;
  endfunction

  function automatic logic [CW-1:0] max3(input logic [CW-1:0] a, b, c);
    logic [CW-1:0] m;
    m = (a > b) ? a : b;
    max3 = (c > m) ? c : m;
  endfunction

  logic signed [EW-1:0] area_c;
  assign area_c = (ext(vx[1]) - ext(vx[0])) * (ext(vy[2]) - ext(vy[0]))
                - (ext(vx[2]) - ext(vx[0])) * (ext(vy[1]) - ext(vy[0]));

  logic [CW-1:0] xmin_c, xmax_c, ymin_c, ymax_c, xs_c;
  assign xmin_c = min3(vx[0], vx[1], vx[2]);
  assign xmax_c = max3(vx[0], vx[1], vx[2]);
  assign ymin_c = min3(vy[0], vy[1], vy[2]);
  assign ymax_c = max3(vy[0], vy[1], vy[2]);
  assign xs_c   = {xmin_c[CW-1:1], 1'b0};

  logic signed [EW-1:0] a_c [3];
  logic signed [EW-1:0] b_c [3];
  logic signed [EW-1:0] e0_c [3];
  logic signed [EW-1:0] e_odd [3];
  logic [2:0] own_c, hit_even, hit_odd;

  for (genvar i = 0; i < 3; i++) begin : g_edge
    localparam int J = (i + 1) % 3;
    assign a_c[i]  = ext(vy[i]) - ext(vy[J]);
    assign b_c[i]  = ext(vx[J]) - ext(vx[i]);
    assign e0_c[i] = b_c[i] * (ext(ymin_c) - ext(vy[i]))
                   + a_c[i] * (ext(xs_c) - ext(vx[i]));
    assign own_c[i] = (a_c[i] > 0) || (a_c[i] == 0 && b_c[i] < 0);
    assign e_odd[i] = e_cur[i] + a_q[i];
    assign hit_even[i] = (e_cur[i] > 0) || (e_cur[i] == 0 && own_q[i]);
    assign hit_odd[i]  = (e_odd[i] > 0) || (e_odd[i] == 0 && own_q[i]);
  end

  logic in_even, in_odd, step, last_col, last_row;
  assign in_even  = &hit_even;
  assign in_odd   = &hit_odd;
  assign last_col = (x_q == xl_q);
  assign last_row = (y_q == ymax_q);
  assign step     = !wr_valid || wr_ready;

  assign cmd_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign wr_valid  = (state == S_SCAN) && (in_even || in_odd);
  assign wr_addr   = {y_q, x_q[CW-1:1]};
  assign wr_data   = {color_q, color_q};
  assign wr_be     = {{HB{in_odd}}, {HB{in_even}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:   if (cmd_valid) state <= S_ORIENT;
        S_ORIENT: state <= (area_c == 0) ? S_IDLE : S_PREP;
        S_PREP:   state <= S_SCAN;
        S_SCAN:   if (step && last_col && last_row) state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    case (state)
      S_IDLE: if (cmd_valid) begin
        vx[0] <= v0_x; vy[0] <= v0_y;
        vx[1] <= v1_x; vy[1] <= v1_y;
        vx[2] <= v2_x; vy[2] <= v2_y;
        color_q <= color;
      end
      S_ORIENT: if (area_c < 0) begin
        vx[1] <= vx[2]; vy[1] <= vy[2];
        vx[2] <= vx[1]; vy[2] <= vy[1];
      end
      S_PREP: begin
        for (int i = 0; i < 3; i++) begin
          a_q[i]   <= a_c[i];
          b_q[i]   <= b_c[i];
          e_row[i] <= e0_c[i];
          e_cur[i] <= e0_c[i];
        end
        own_q  <= own_c;
        xs_q   <= xs_c;
        xl_q   <= {xmax_c[CW-1:1], 1'b0};
        ymax_q <= ymax_c;
        x_q    <= xs_c;
        y_q    <= ymin_c;
      end
      S_SCAN: if (step) begin
        if (last_col) begin
          if (!last_row) begin
            y_q <= y_q + CW'(1);
            x_q <= xs_q;
            for (int i = 0; i < 3; i++) begin
              e_row[i] <= e_row[i] + b_q[i];
              e_cur[i] <= e_row[i] + b_q[i];
            end
          end
        end else begin
          x_q <= x_q + CW'(2);
          for (int i = 0; i < 3; i++) e_cur[i] <= e_cur[i] + a_q[i] + a_q[i];
        end
      end
      default: ;
    endcase
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be));

  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !wr_valid || (wr_addr > $past(wr_addr)));

  a_r7_in_box: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[2*CW-2:CW-1] <= ymax_q) && (wr_addr[CW-2:0] <= xl_q[CW-1:1]));

  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy && !cmd_ready && !wr_valid);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid);

endmodule

// File: tb/tri_pair_raster_tb.sv
module tri_pair_raster_tb_top;
  localparam int CW = 8;
  localparam int PW = 32;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready, busy, wr_valid, wr_ready = 0;
  logic [CW-1:0] v0_x = 0, v0_y = 0, v1_x = 0, v1_y = 0, v2_x = 0, v2_y = 0;
  logic [PW-1:0] color = 0;
  logic [2*CW-2:0] wr_addr;
  logic [2*PW-1:0] wr_data;
  logic [PW/4-1:0] wr_be;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_pair_raster #(.CW(CW), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .v0_x(v0_x), .v0_y(v0_y), .v1_x(v1_x), .v1_y(v1_y), .v2_x(v2_x), .v2_y(v2_y),
    .color(color), .busy(busy), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be));

  int checks = 0, errors = 0;
  int exp_addr [4096];
  logic [7:0] exp_be [4096];
  int n_exp, n_pairs;
  bit drawn [65536];
  int overlaps;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit edge_ok(int ax, int ay, int bx, int by, int px, int py);
    int e;
    bit own;
    e = (bx - ax) * (py - ay) - (by - ay) * (px - ax);
    own = (ay > by) || (ay == by && bx < ax);
    return (e > 0) || (e == 0 && own);
  endfunction

  function automatic bit covered(int x0, int y0, int x1, int y1, int x2, int y2, int px, int py);
    int d, t;
    d = (x1 - x0) * (y2 - y0) - (x2 - x0) * (y1 - y0);
    if (d == 0) return 0;
    if (d < 0) begin
      t = x1; x1 = x2; x2 = t;
      t = y1; y1 = y2; y2 = t;
    end
    return edge_ok(x0, y0, x1, y1, px, py) && edge_ok(x1, y1, x2, y2, px, py)
        && edge_ok(x2, y2, x0, y0, px, py);
  endfunction

  task automatic build_ref(input int x0, y0, x1, y1, x2, y2);
    int xmn, xmx, ymn, ymx;
    bit ev, od;
    xmn = x0; if (x1 < xmn) xmn = x1; if (x2 < xmn) xmn = x2;
    xmx = x0; if (x1 > xmx) xmx = x1; if (x2 > xmx) xmx = x2;
    ymn = y0; if (y1 < ymn) ymn = y1; if (y2 < ymn) ymn = y2;
    ymx = y0; if (y1 > ymx) ymx = y1; if (y2 > ymx) ymx = y2;
    n_exp = 0; n_pairs = 0;
    for (int y = ymn; y <= ymx; y++)
      for (int x = xmn & ~1; x <= xmx; x += 2) begin
        n_pairs++;
        ev = covered(x0, y0, x1, y1, x2, y2, x, y);
        od = covered(x0, y0, x1, y1, x2, y2, x + 1, y);
        if (ev || od) begin
          exp_addr[n_exp] = y * (1 << (CW - 1)) + x / 2;
          exp_be[n_exp] = {{4{od}}, {4{ev}}};
          n_exp++;
        end
      end
  endtask

  task automatic run_tri(input int x0, y0, x1, y1, x2, y2, input bit full, input string tag);
    int got, busy_cnt, px, py;
    logic [31:0] col;
    col = $urandom;
    build_ref(x0, y0, x1, y1, x2, y2);
    @(negedge clk);
    chk(cmd_ready && !busy, "R1", {tag, " idle before command"}, {busy, cmd_ready}, 64'h1);
    v0_x = CW'(x0); v0_y = CW'(y0); v1_x = CW'(x1); v1_y = CW'(y1);
    v2_x = CW'(x2); v2_y = CW'(y2); color = col; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy && !cmd_ready, "R1", {tag, " busy after accept"}, {busy, cmd_ready}, 64'h2);
    wr_ready = full ? 1'b1 : ($urandom % 4 != 0);
    got = 0; busy_cnt = busy ? 1 : 0;
    forever begin
      if (wr_valid && wr_ready) begin
        if (got < n_exp) begin
          chk(wr_addr == exp_addr[got][2*CW-2:0], "R3", {tag, " address"}, wr_addr, exp_addr[got]);
          chk(wr_be == exp_be[got], "R5", {tag, " byte enables"}, wr_be, exp_be[got]);
          chk(wr_data == {col, col}, "R5", {tag, " data"}, wr_data, {col, col});
        end
        chk(wr_be != 0, "R6", {tag, " nonzero mask"}, wr_be, 8'hFF);
        py = int'(wr_addr) >> (CW - 1);
        px = (int'(wr_addr) & ((1 << (CW - 1)) - 1)) * 2;
        if (wr_be[0]) begin
          if (drawn[py * 256 + px]) overlaps++;
          drawn[py * 256 + px] = 1;
        end
        if (wr_be[4]) begin
          if (drawn[py * 256 + px + 1]) overlaps++;
          drawn[py * 256 + px + 1] = 1;
        end
        got++;
      end
      @(negedge clk);
      wr_ready = full ? 1'b1 : ($urandom % 4 != 0);
      if (!busy || busy_cnt > 20000) break;
      busy_cnt++;
    end
    chk(got == n_exp, "R3", {tag, " write count"}, got, n_exp);
    if (full) begin
      if (n_exp == 0 && n_pairs > 0 &&
          (x1 - x0) * (y2 - y0) - (x2 - x0) * (y1 - y0) == 0)
        chk(busy_cnt == 1, "R9", {tag, " degenerate busy cycles"}, busy_cnt, 1);
      else
        chk(busy_cnt == 2 + n_pairs, "R8", {tag, " busy cycles"}, busy_cnt, 2 + n_pairs);
    end
    for (int k = 0; k < 3; k++) begin
      chk(!wr_valid && cmd_ready, "R7", {tag, " quiet after end"}, {wr_valid, cmd_ready}, 64'h1);
      @(negedge clk);
    end
  endtask

  task automatic clear_map();
    for (int i = 0; i < 65536; i++) drawn[i] = 0;
    overlaps = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected 0", WATCHDOG);
    summary();
    $finish;
  end

  initial begin
    int bx, by, cnt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !busy && !wr_valid, "R1", "reset state",
        {cmd_ready, busy, wr_valid}, 64'h4);

    clear_map();
    run_tri(2, 2, 20, 4, 7, 19, 1, "directed ccw");
    run_tri(2, 2, 7, 19, 20, 4, 1, "R2 reversed winding");
    run_tri(7, 19, 2, 2, 20, 4, 0, "R2 rotated order");
    run_tri(10, 10, 20, 20, 30, 30, 1, "R9 collinear");
    run_tri(5, 5, 5, 5, 5, 5, 1, "R9 point");
    run_tri(3, 3, 3, 3, 3, 3, 0, "R9 point stalled");
    run_tri(250, 250, 255, 252, 251, 255, 1, "R7 right border");
    run_tri(0, 0, 1, 0, 0, 1, 1, "R5 single pixel odd");
    run_tri(1, 0, 1, 9, 9, 9, 1, "R5 odd left edge");

    clear_map();
    run_tri(10, 10, 40, 10, 10, 40, 0, "R4 shared A");
    run_tri(40, 10, 40, 40, 10, 40, 0, "R4 shared B");
    chk(overlaps == 0, "R4", "diagonal shared edge overlap", overlaps, 0);
    clear_map();
    run_tri(60, 60, 61, 75, 90, 64, 1, "R4 fan A");
    run_tri(60, 60, 90, 64, 77, 50, 1, "R4 fan B");
    run_tri(90, 64, 61, 75, 95, 80, 0, "R4 fan C");
    chk(overlaps == 0, "R4", "fan shared edge overlap", overlaps, 0);

    for (int n = 0; n < 40; n++) begin
      bx = $urandom % 214; by = $urandom % 214;
      clear_map();
      run_tri(bx + $urandom % 41, by + $urandom % 41, bx + $urandom % 41,
              by + $urandom % 41, bx + $urandom % 41, by + $urandom % 41,
              (n % 3 == 0), "R3 random");
      cnt = 0;
      chk(overlaps == 0, "R6", "random no duplicate pixel", overlaps, cnt);
    end

    summary();
    $finish;
  end
endmodule